// File: doc/BRIEF.md
# PCI Configuration Header Register Subset

This block holds a handful of type-0 configuration header registers for a function that masters the bus: the cache line size with its value filter, the latency timer, the header type byte, and three base address registers. Software reaches them through a dword-addressed configuration port with per-lane byte enables. Reads return data one cycle after the request, with a valid strobe.

The stored cache line size also drives an enable for the memory-write-and-invalidate command. The latency timer value is loaded into a down-counter each time the function gains bus ownership, and a flag shows when the allowed tenure has run out. The header type byte comes from a strap that is sampled while reset is held. The strap marks the function as part of a multi-function card or as a single function.

Top module: `cfg_hdr_subset`

## Requirements
- R1: Dword 3, byte lane 0, bits [7:0] is the cache line size. Writing exactly 08h stores 08h and writing exactly 10h stores 10h.
- R2: Writing any other value to the cache line size byte clears it, including a legal value stored earlier, so it reads back as 00h.
- R3: mwi_en_o is high exactly when the cache line size holds 08h or 10h. It changes in the cycle after the write.
- R4: Dword 3, byte lane 1, bits [15:8] is the latency timer, a fully writable byte.
- R5: Dword 3, byte lane 2, bits [23:16] reads 80h if hdr_multi_fn_i was high during reset and 00h otherwise. Writes do not change it, and neither does a later change of the strap. Lane 3 reads zero.
- R6: Dword 4 is a 4 KiB memory BAR. Bits [31:12] are writable and bits [11:0] read zero, so writing all ones reads back FFFFF000h.
- R7: Dword 5 is a 64-byte I/O BAR. Bits [31:6] are writable, bits [5:1] read zero and bit 0 reads one, so writing all ones reads back FFFFFFC1h.
- R8: Dword 6 is a 1 MiB memory BAR. Writing all ones reads back FFF00000h.
- R9: A write changes only the byte lanes whose cfg_be_i bit is set. cfg_be_i bit n covers cfg_wdata_i bits [8n+7:8n].
- R10: Reads of dwords 0 to 2 and 7 to 15 return zero. Writes to those dwords change no register.
- R11: A read request sampled at a clock edge gives cfg_rvalid_o and cfg_rdata_o after that edge, for one cycle.
- R12: Call the edge that first samples bus_own_i high the grant edge, and let L be the latency timer value. tenure_exp_o is low until L edges after the grant edge and then goes high. With L = 0 it is high right after the grant edge.
- R13: tenure_exp_o is low after any edge that samples bus_own_i low. A new grant reloads the count.
- R14: After reset, the cache line size, the latency timer and all writable BAR bits are zero, and mwi_en_o and tenure_exp_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_multi_fn_i | input | 1 | Multi-function strap, sampled during reset |
| cfg_addr_i | input | 4 | Dword index into the configuration header |
| cfg_wr_i | input | 1 | Write request |
| cfg_rd_i | input | 1 | Read request |
| cfg_be_i | input | 4 | Byte-lane enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, one cycle after the request |
| cfg_rvalid_o | output | 1 | Read data valid |
| bus_own_i | input | 1 | Function currently owns the bus as master |
| mwi_en_o | output | 1 | Memory-write-and-invalidate may be used |
| tenure_exp_o | output | 1 | Latency timer tenure exhausted |

## Verification
The bench writes illegal cache line sizes on top of legal ones. A filter that kept the old value, or that stored the raw byte, would leave a non-zero read and a stuck invalidate enable. It writes all ones to each BAR and applies partial byte enables. Wrong size masks or ignored enables show up as wrong read-back patterns, and an I/O BAR that lost its type bit reads an even value. The tenure flag is timed against a latency of five clocks and a latency of zero, and is then checked across release and re-grant, which catches off-by-one counting and a missing reload. The header strap is changed after reset and then reset again with the other value, which catches a strap that is passed straight through or never sampled.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  typedef logic [31:0] dword_t;
  typedef enum logic [1:0] {CLS_NONE = 2'd0, CLS_8 = 2'd1, CLS_16 = 2'd2} cls_t;
  localparam int unsigned DW_MISC = 3;
  localparam int unsigned DW_BAR0 = 4;
  localparam int unsigned BAR_N   = 3;
  localparam logic [7:0] CLS_VAL_8  = 8'h08;
  localparam logic [7:0] CLS_VAL_16 = 8'h10;
endpackage

// File: rtl/cls_filter.sv
module cls_filter
  import cfg_hdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] cls_o,
  output logic       mwi_o
);
  cls_t cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cls_q <= CLS_NONE;
    else if (wr_i) begin
      if (wdata_i == CLS_VAL_8)       cls_q <= CLS_8;
      else if (wdata_i == CLS_VAL_16) cls_q <= CLS_16;
      else                            cls_q <= CLS_NONE;
    end
  end

  always_comb begin
    case (cls_q)
      CLS_8:   cls_o = CLS_VAL_8;
      CLS_16:  cls_o = CLS_VAL_16;
      default: cls_o = 8'h00;
    endcase
  end
  assign mwi_o = (cls_q != CLS_NONE);

  // R1
  cls_legal_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (wdata_i == CLS_VAL_16) |=> cls_o == CLS_VAL_16);
  // R2
  cls_illegal_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (wdata_i != CLS_VAL_8) && (wdata_i != CLS_VAL_16) |=> cls_o == 8'h00);
  // R3
  mwi_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (wdata_i == CLS_VAL_8) |=> mwi_o);
endmodule

// File: rtl/bar_reg.sv
module bar_reg
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12,
  parameter bit          IS_IO     = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] be_i,
  input  dword_t     wdata_i,
  output dword_t     val_o
);
  localparam dword_t WR_MASK  = dword_t'({32{1'b1}} << SIZE_LOG2);
  localparam dword_t TYPE_VAL = {31'd0, IS_IO};

  dword_t base_q, lane_mask;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_mask[8*i +: 8] = {8{be_i[i]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (wr_i) base_q <= (base_q & ~(lane_mask & WR_MASK)) | (wdata_i & lane_mask & WR_MASK);
  end

  assign val_o = base_q | TYPE_VAL;

  // R6 R7 R8
  bar_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (be_i == 4'hF) && (wdata_i == 32'hFFFF_FFFF) |=> val_o == (WR_MASK | TYPE_VAL));
  // R9
  bar_lane_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !be_i[0] |=> val_o[7:0] == $past(val_o[7:0]));
endmodule

// File: rtl/tenure_cnt.sv
module tenure_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             own_i,
  input  logic [CNT_W-1:0] lat_i,
  output logic             exp_o
);
  logic             own_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      own_q <= own_i;
      if (own_i && !own_q)               cnt_q <= lat_i;
      else if (own_i && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign exp_o = own_q && (cnt_q == '0);

  // R12
  tenure_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_i && !own_q |=> cnt_q == $past(lat_i));
  // R13
  tenure_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_i |=> !exp_o);
endmodule

// File: rtl/cfg_hdr_subset.sv
module cfg_hdr_subset
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned BAR0_LOG2 = 12,
  parameter int unsigned BAR1_LOG2 = 6,
  parameter int unsigned BAR2_LOG2 = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_multi_fn_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_rd_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_rvalid_o,
  input  logic              bus_own_i,
  output logic              mwi_en_o,
  output logic              tenure_exp_o
);
  localparam int unsigned BAR_LOG2 [BAR_N] = '{BAR0_LOG2, BAR1_LOG2, BAR2_LOG2};
  localparam bit          BAR_IO   [BAR_N] = '{1'b0, 1'b1, 1'b0};

  logic       misc_sel, hdr_q;
  logic [7:0] cls_val, lat_q;
  dword_t     bar_val [BAR_N];
  dword_t     rd_mux, rdata_q;
  logic       rvalid_q;

  assign misc_sel = (cfg_addr_i == ADDR_W'(DW_MISC));

  // strap captured while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hdr_q <= hdr_multi_fn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (cfg_wr_i && misc_sel && cfg_be_i[1]) lat_q <= cfg_wdata_i[15:8];
  end

  cls_filter u_cls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i && misc_sel && cfg_be_i[0]),
    .wdata_i (cfg_wdata_i[7:0]),
    .cls_o   (cls_val),
    .mwi_o   (mwi_en_o)
  );

  for (genvar b = 0; b < BAR_N; b++) begin : g_bar
    bar_reg #(
      .SIZE_LOG2 (BAR_LOG2[b]),
      .IS_IO     (BAR_IO[b])
    ) u_bar (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cfg_wr_i && (cfg_addr_i == ADDR_W'(DW_BAR0 + b))),
      .be_i    (cfg_be_i),
      .wdata_i (cfg_wdata_i),
      .val_o   (bar_val[b])
    );
  end

  tenure_cnt #(.CNT_W(8)) u_tenure (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .own_i  (bus_own_i),
    .lat_i  (lat_q),
    .exp_o  (tenure_exp_o)
  );

  always_comb begin
    rd_mux = '0;
    if (misc_sel) rd_mux = {8'h00, hdr_q, 7'd0, lat_q, cls_val};
    for (int b = 0; b < BAR_N; b++)
      if (cfg_addr_i == ADDR_W'(DW_BAR0 + b)) rd_mux = bar_val[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cfg_rd_i;
      if (cfg_rd_i) rdata_q <= rd_mux;
    end
  end

  assign cfg_rdata_o  = rdata_q;
  assign cfg_rvalid_o = rvalid_q;

  // R11
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rd_i |=> cfg_rvalid_o);
  // R5
  hdr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(hdr_q));
  // R4
  lat_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && misc_sel && cfg_be_i[1] |=> lat_q == $past(cfg_wdata_i[15:8]));

  initial assert (CNT_W == 8) else $error("latency timer is one byte wide");
endmodule

// File: tb/cfg_hdr_subset_tb.sv
module cfg_hdr_subset_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, own = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, mwi, texp;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  cfg_hdr_subset u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hdr_multi_fn_i(strap),
    .cfg_addr_i(addr), .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .cfg_rvalid_o(rvalid),
    .bus_own_i(own), .mwi_en_o(mwi), .tenure_exp_o(texp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk("R11 unexpected rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic do_wr(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    exp_q.push_back(expv); tag_q.push_back(tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state, R5 strap high
    chk("R14 mwi after reset", {31'd0, mwi}, 32'd0);
    chk("R14 tenure flag after reset", {31'd0, texp}, 32'd0);
    chk("R11 no rvalid idle", {31'd0, rvalid}, 32'd0);
    do_rd(4'd3, 32'h0080_0000, "R14 R5 dword3 reset");
    do_rd(4'd4, 32'h0000_0000, "R14 BAR0 reset");
    do_rd(4'd5, 32'h0000_0001, "R14 R7 BAR1 reset");
    do_rd(4'd6, 32'h0000_0000, "R14 BAR2 reset");
    // R1 R3
    do_wr(4'd3, 4'b0001, 32'h0000_0008);
    chk("R3 mwi after 08h", {31'd0, mwi}, 32'd1);
    do_rd(4'd3, 32'h0080_0008, "R1 cls 08h");
    do_wr(4'd3, 4'b0001, 32'h0000_0010);
    do_rd(4'd3, 32'h0080_0010, "R1 cls 10h");
    chk("R3 mwi after 10h", {31'd0, mwi}, 32'd1);
    // R2
    do_wr(4'd3, 4'b0001, 32'h0000_0018);
    do_rd(4'd3, 32'h0080_0000, "R2 cls 18h");
    chk("R3 mwi after 18h", {31'd0, mwi}, 32'd0);
    do_wr(4'd3, 4'b0001, 32'h0000_0008);
    do_wr(4'd3, 4'b0001, 32'h0000_0009);
    do_rd(4'd3, 32'h0080_0000, "R2 cls 09h over 08h");
    chk("R3 mwi after 09h", {31'd0, mwi}, 32'd0);
    // R4 R9
    do_wr(4'd3, 4'b0010, 32'h0000_A508);
    do_rd(4'd3, 32'h0080_A500, "R4 R9 latency lane only");
    // R5 write to header and lane3, strap change
    do_wr(4'd3, 4'b1111, 32'hFFFF_FFFF);
    strap = 1'b0;
    do_rd(4'd3, 32'h0080_FF00, "R5 header held");
    // R6 R7 R8
    do_wr(4'd4, 4'b1111, 32'hFFFF_FFFF);
    do_wr(4'd5, 4'b1111, 32'hFFFF_FFFF);
    do_wr(4'd6, 4'b1111, 32'hFFFF_FFFF);
    do_rd(4'd4, 32'hFFFF_F000, "R6 BAR0 size");
    do_rd(4'd5, 32'hFFFF_FFC1, "R7 BAR1 size");
    do_rd(4'd6, 32'hFFF0_0000, "R8 BAR2 size");
    // R9
    do_wr(4'd6, 4'b1000, 32'h1234_5678);
    do_rd(4'd6, 32'h12F0_0000, "R9 BAR2 lane3");
    do_wr(4'd6, 4'b0100, 32'hAB34_CDEF);
    do_rd(4'd6, 32'h1230_0000, "R9 BAR2 lane2");
    // R10
    do_rd(4'd0, 32'h0, "R10 dword0");
    do_rd(4'd2, 32'h0, "R10 dword2");
    do_wr(4'd7, 4'b1111, 32'hFFFF_FFFF);
    do_wr(4'd15, 4'b1111, 32'h0000_0000);
    do_rd(4'd7, 32'h0, "R10 dword7");
    do_rd(4'd15, 32'h0, "R10 dword15");
    do_rd(4'd4, 32'hFFFF_F000, "R10 BAR0 untouched");
    do_rd(4'd3, 32'h0080_FF00, "R10 dword3 untouched");
    // R12 latency 5
    do_wr(4'd3, 4'b0010, 32'h0000_0500);
    @(negedge clk); own = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12 flag low before L edges", {31'd0, texp}, 32'd0);
    @(negedge clk);
    chk("R12 flag high at L edges", {31'd0, texp}, 32'd1);
    @(negedge clk);
    chk("R12 flag stays high", {31'd0, texp}, 32'd1);
    // R13
    own = 1'b0;
    @(negedge clk);
    chk("R13 flag cleared on release", {31'd0, texp}, 32'd0);
    own = 1'b1;
    @(negedge clk);
    chk("R13 regrant reloads", {31'd0, texp}, 32'd0);
    own = 1'b0;
    @(negedge clk);
    // R12 latency 0
    do_wr(4'd3, 4'b0010, 32'h0000_0000);
    own = 1'b1;
    @(negedge clk);
    chk("R12 zero latency", {31'd0, texp}, 32'd1);
    own = 1'b0;
    @(negedge clk);
    // R14 R5 second reset with strap low
    do_wr(4'd3, 4'b0011, 32'h0000_3310);
    do_reset(1'b0);
    chk("R14 mwi after second reset", {31'd0, mwi}, 32'd0);
    do_rd(4'd3, 32'h0000_0000, "R5 R14 strap low");
    do_rd(4'd5, 32'h0000_0001, "R14 BAR1 cleared");
    do_rd(4'd6, 32'h0000_0000, "R14 BAR2 cleared");
    repeat (3) @(negedge clk);
    chk("R11 all reads returned", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule